// File: doc/BRIEF.md
# Constant Off-Time PWM Current Chopper

This block regulates the winding current of each H-bridge in a stepper drive. It uses a fixed recirculation interval rather than a fixed PWM period. Each bridge has an independent chopper lane. A lane takes an asynchronous comparator flag, which is high while the sensed current is above that bridge's reference, and a bridge enable. It drives a one-hot command to the gate logic: either drive the winding or let it recirculate.

While driving, the lane watches the synchronised flag. It ignores the flag during a blanking window that starts at every turn-on, which covers the diode recovery spike. It also holds the drive for a minimum on time. When the flag is accepted, the lane recirculates for a programmed number of cycles and then returns to driving by itself. The dead time that the downstream gate logic inserts adds to the effective off time.

The blanking, minimum-on and off-time counts are run-time inputs for each lane. They are held stable while the lane is enabled. The off-time count is wide enough for intervals in the millisecond range at the core clock. A one-cycle trip pulse marks each accepted over-threshold event.

Top module: `chop_bank`

## Requirements
- R1: During reset, and in every cycle after a cycle in which a lane's enable was sampled low, that lane's `drive_on`, `recirc_on` and `trip_pulse` are all 0. This holds whatever the comparator flag does.
- R2: When the enable of an idle lane is sampled high at a clock edge, `drive_on` is 1 from that edge on.
- R3: An accepted over-threshold ends the drive phase at the next edge. `recirc_on` rises and `trip_pulse` is 1 for exactly that first recirculation cycle.
- R4: In each drive phase, the flag is ignored for the first B cycles (B = blanking count). With the flag held high, the drive phase lasts at least B+1 cycles.
- R5: A drive phase ended by the flag lasts at least max(M,1) cycles (M = minimum-on count). With the flag held high from turn-on, it lasts exactly max(B+1, M) cycles.
- R6: The recirculation phase lasts exactly max(O,1) cycles (O = off count), whatever the flag does. `drive_on` is 1 in the following cycle.
- R7: The flag passes through a two-flop synchroniser. A rising flag, applied between edges during an unblanked drive phase, raises `recirc_on` after the third following clock edge and not before it.
- R8: Dropping enable during either phase makes the lane idle at the next edge and clears its timers. On re-enable, the lane starts a fresh drive phase with full blanking and a full off time.
- R9: The lanes are independent. Activity on one lane does not change another lane's outputs.
- R10: `drive_on` and `recirc_on` of a lane are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en | input | NUM_BR | Per-lane enable; low forces idle |
| over_ref_raw | input | NUM_BR | Asynchronous comparator flag per lane, high when current exceeds reference |
| blank_len | input | NUM_BR*BLANK_W | Per-lane blanking count B, lane i in bits [i*BLANK_W +: BLANK_W] |
| min_on_len | input | NUM_BR*MINON_W | Per-lane minimum-on count M, lane i in bits [i*MINON_W +: MINON_W] |
| off_len | input | NUM_BR*OFF_W | Per-lane off count O, lane i in bits [i*OFF_W +: OFF_W] |
| drive_on | output | NUM_BR | Command: bridge drives the winding |
| recirc_on | output | NUM_BR | Command and status: lane in recirculation |
| trip_pulse | output | NUM_BR | One-cycle pulse on each accepted over-threshold |

## Verification
Several rules are checked on every cycle: idle output after a disable, the one-hot command, trip pulse placement and width, the lower bound on drive-phase length, the exact recirculation length, and the automatic return to drive. Synchroniser latency is not checked that way, because it can only be seen against the raw input's timing. The same goes for flag pulses that fall wholly inside blanking, and for timer clearing across a disable and re-enable. The bench's directed scenarios show these, together with cross-lane independence.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int DEF_NUM_BR   = 2;
    localparam int DEF_BLANK_W  = 8;
    localparam int DEF_MINON_W  = 8;
    localparam int DEF_OFF_W    = 20;
    localparam int DEF_SYNC_STG = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DRIVE  = 2'd1,
        PH_RECIRC = 2'd2
    } phase_e;

    typedef struct packed {
        logic drive;
        logic recirc;
        logic trip;
    } chop_cmd_t;

    function automatic int chop_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int STAGES = chop_pkg::DEF_SYNC_STG
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-2:0], d};
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/chop_count.sv
module chop_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
    import chop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      flag,
    input  logic      blank_done,
    input  logic      min_done,
    input  logic      off_done,
    output logic      clr_on,
    output logic      clr_off,
    output chop_cmd_t cmd
);
    phase_e phase, phase_nxt;
    logic   accept;
    logic   trip_q;

    always_comb begin
        phase_nxt = phase;
        accept    = 1'b0;
        if (!en) begin
            phase_nxt = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   phase_nxt = PH_DRIVE;
                PH_DRIVE: begin
                    if (flag && blank_done && min_done) begin
                        phase_nxt = PH_RECIRC;
                        accept    = 1'b1;
                    end
                end
                PH_RECIRC: begin
                    if (off_done) begin
                        phase_nxt = PH_DRIVE;
                    end
                end
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Timers run only while the phase they time persists across the edge.
    assign clr_on  = (phase != PH_DRIVE)  || (phase_nxt != PH_DRIVE);
    assign clr_off = (phase != PH_RECIRC) || (phase_nxt != PH_RECIRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            trip_q <= 1'b0;
        end else begin
            phase  <= phase_nxt;
            trip_q <= accept;
        end
    end

    always_comb begin
        cmd.drive  = (phase == PH_DRIVE);
        cmd.recirc = (phase == PH_RECIRC);
        cmd.trip   = trip_q;
    end
endmodule

// File: rtl/chop_lane.sv
module chop_lane
    import chop_pkg::*;
#(
    parameter int BLANK_W  = DEF_BLANK_W,
    parameter int MINON_W  = DEF_MINON_W,
    parameter int OFF_W    = DEF_OFF_W,
    parameter int SYNC_STG = DEF_SYNC_STG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               flag_raw,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic [MINON_W-1:0] min_on_len,
    input  logic [OFF_W-1:0]   off_len,
    output chop_cmd_t          cmd
);
    // One spare bit so the saturated count exceeds any programmed window.
    localparam int ON_W = chop_max(BLANK_W, MINON_W) + 1;

    logic            flag_s;
    logic            clr_on, clr_off;
    logic [ON_W-1:0] on_cnt;
    logic [OFF_W-1:0] off_cnt;
    logic [ON_W:0]   on_elapsed;
    logic [OFF_W:0]  off_elapsed;
    logic            blank_done, min_done, off_done;

    chop_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flag_raw),
        .q   (flag_s)
    );

    chop_count #(.W(ON_W)) u_on_tmr (
        .clk (clk),
        .rst (rst),
        .clr (clr_on),
        .cnt (on_cnt)
    );

    chop_count #(.W(OFF_W)) u_off_tmr (
        .clk (clk),
        .rst (rst),
        .clr (clr_off),
        .cnt (off_cnt)
    );

    // Elapsed counts include the current cycle of the phase.
    assign on_elapsed  = {1'b0, on_cnt} + (ON_W+1)'(1);
    assign off_elapsed = {1'b0, off_cnt} + (OFF_W+1)'(1);

    assign blank_done = (on_cnt >= ON_W'(blank_len));
    assign min_done   = (on_elapsed >= (ON_W+1)'(min_on_len));
    assign off_done   = (off_elapsed >= {1'b0, off_len});

    chop_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .flag       (flag_s),
        .blank_done (blank_done),
        .min_done   (min_done),
        .off_done   (off_done),
        .clr_on     (clr_on),
        .clr_off    (clr_off),
        .cmd        (cmd)
    );
endmodule

// File: rtl/chop_bank.sv
module chop_bank
    import chop_pkg::*;
#(
    parameter int NUM_BR   = DEF_NUM_BR,
    parameter int BLANK_W  = DEF_BLANK_W,
    parameter int MINON_W  = DEF_MINON_W,
    parameter int OFF_W    = DEF_OFF_W,
    parameter int SYNC_STG = DEF_SYNC_STG
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BR-1:0]          bridge_en,
    input  logic [NUM_BR-1:0]          over_ref_raw,
    input  logic [NUM_BR*BLANK_W-1:0]  blank_len,
    input  logic [NUM_BR*MINON_W-1:0]  min_on_len,
    input  logic [NUM_BR*OFF_W-1:0]    off_len,
    output logic [NUM_BR-1:0]          drive_on,
    output logic [NUM_BR-1:0]          recirc_on,
    output logic [NUM_BR-1:0]          trip_pulse
);
    chop_cmd_t lane_cmd [NUM_BR];

    for (genvar i = 0; i < NUM_BR; i++) begin : g_lane
        chop_lane #(
            .BLANK_W  (BLANK_W),
            .MINON_W  (MINON_W),
            .OFF_W    (OFF_W),
            .SYNC_STG (SYNC_STG)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .en         (bridge_en[i]),
            .flag_raw   (over_ref_raw[i]),
            .blank_len  (blank_len[i*BLANK_W +: BLANK_W]),
            .min_on_len (min_on_len[i*MINON_W +: MINON_W]),
            .off_len    (off_len[i*OFF_W +: OFF_W]),
            .cmd        (lane_cmd[i])
        );

        assign drive_on[i]   = lane_cmd[i].drive;
        assign recirc_on[i]  = lane_cmd[i].recirc;
        assign trip_pulse[i] = lane_cmd[i].trip;
    end
endmodule

// File: rtl/chop_bank_chk.sv
module chop_bank_chk #(
    parameter int NUM_BR  = 2,
    parameter int BLANK_W = 8,
    parameter int MINON_W = 8,
    parameter int OFF_W   = 20
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_BR-1:0]         bridge_en,
    input logic [NUM_BR*BLANK_W-1:0] blank_len,
    input logic [NUM_BR*MINON_W-1:0] min_on_len,
    input logic [NUM_BR*OFF_W-1:0]   off_len,
    input logic [NUM_BR-1:0]         drive_on,
    input logic [NUM_BR-1:0]         recirc_on,
    input logic [NUM_BR-1:0]         trip_pulse
);
    for (genvar i = 0; i < NUM_BR; i++) begin : g_chk
        logic [31:0] on_run, off_run;
        logic [31:0] b_v, m_v, o_v;

        assign b_v = 32'(blank_len[i*BLANK_W +: BLANK_W]);
        assign m_v = 32'(min_on_len[i*MINON_W +: MINON_W]);
        assign o_v = 32'(off_len[i*OFF_W +: OFF_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                on_run  <= '0;
                off_run <= '0;
            end else begin
                on_run  <= drive_on[i]  ? on_run + 32'd1  : 32'd0;
                off_run <= recirc_on[i] ? off_run + 32'd1 : 32'd0;
            end
        end

        p_idle_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
            !bridge_en[i] |=> (!drive_on[i] && !recirc_on[i] && !trip_pulse[i]));

        p_start_drive_r2: assert property (@(posedge clk) disable iff (rst)
            ($past(bridge_en[i]) && !$past(drive_on[i]) && !$past(recirc_on[i]))
            |-> drive_on[i]);

        p_trip_first_off_r3: assert property (@(posedge clk) disable iff (rst)
            trip_pulse[i] |-> (recirc_on[i] && $past(drive_on[i])));

        p_trip_single_r3: assert property (@(posedge clk) disable iff (rst)
            trip_pulse[i] |=> !trip_pulse[i]);

        p_min_on_r5: assert property (@(posedge clk) disable iff (rst)
            (recirc_on[i] && $past(drive_on[i]))
            |-> (on_run >= ((m_v == 32'd0) ? 32'd1 : m_v) && on_run > b_v));

        p_off_len_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(recirc_on[i]) && !recirc_on[i] && $past(bridge_en[i]))
            |-> (off_run == ((o_v == 32'd0) ? 32'd1 : o_v)));

        p_off_to_drive_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(recirc_on[i]) && !recirc_on[i] && $past(bridge_en[i]))
            |-> drive_on[i]);

        p_onehot_cmd_r10: assert property (@(posedge clk) disable iff (rst)
            !(drive_on[i] && recirc_on[i]));
    end
endmodule

bind chop_bank chop_bank_chk #(
    .NUM_BR  (NUM_BR),
    .BLANK_W (BLANK_W),
    .MINON_W (MINON_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bridge_en  (bridge_en),
    .blank_len  (blank_len),
    .min_on_len (min_on_len),
    .off_len    (off_len),
    .drive_on   (drive_on),
    .recirc_on  (recirc_on),
    .trip_pulse (trip_pulse)
);

// File: tb/chop_bank_bench.sv
`timescale 1ns/1ps
module chop_bank_bench;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int MW = 8;
    localparam int OW = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB-1:0]   en  = '0;
    logic [NB-1:0]   raw = '0;
    logic [NB*BW-1:0] blank = '0;
    logic [NB*MW-1:0] minon = '0;
    logic [NB*OW-1:0] offl  = '0;
    logic [NB-1:0]   drive_on, recirc_on, trip_pulse;

    int total = 0;
    int bad   = 0;
    int both_cnt  = 0;
    int trip1_cnt = 0;

    always #4 clk = ~clk;

    chop_bank #(.NUM_BR(NB), .BLANK_W(BW), .MINON_W(MW), .OFF_W(OW)) u_chop_bank (
        .clk          (clk),
        .rst          (rst),
        .bridge_en    (en),
        .over_ref_raw (raw),
        .blank_len    (blank),
        .min_on_len   (minon),
        .off_len      (offl),
        .drive_on     (drive_on),
        .recirc_on    (recirc_on),
        .trip_pulse   (trip_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NB; i++) begin
                if (drive_on[i] && recirc_on[i]) both_cnt++;
            end
            if (trip_pulse[1]) trip1_cnt++;
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int br, input int b, input int m, input int o);
        blank[br*BW +: BW] = BW'(b);
        minon[br*MW +: MW] = MW'(m);
        offl[br*OW +: OW]  = OW'(o);
    endtask

    function automatic bit sig(input int br, input bit sel_off);
        return sel_off ? recirc_on[br] : drive_on[br];
    endfunction

    // Called at a negedge; returns length of the next run of the chosen signal.
    task automatic run_len(input int br, input bit sel_off, output int n);
        int guard = 0;
        n = 0;
        while (!sig(br, sel_off) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        while (sig(br, sel_off) && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiesce();
        en  = '0;
        raw = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        raw = '1;
        repeat (4) @(negedge clk);
        chk_eq("R1 drive in reset", int'(drive_on), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R1 drive while disabled", int'(drive_on), 0);
        chk_eq("R1 recirc while disabled", int'(recirc_on), 0);
        chk_eq("R1 trip while disabled", int'(trip_pulse), 0);
        quiesce();
    endtask

    task automatic t_sync_latency();
        set_cfg(0, 0, 1, 10);
        en[0] = 1'b1;
        @(negedge clk);
        chk_eq("R2 drive after enable", int'(drive_on[0]), 1);
        repeat (4) @(negedge clk);
        raw[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk_eq("R7 no trip after two edges", int'(recirc_on[0]), 0);
        @(negedge clk);
        chk_eq("R7 recirc after third edge", int'(recirc_on[0]), 1);
        chk_eq("R3 trip with first off cycle", int'(trip_pulse[0]), 1);
        quiesce();
    endtask

    task automatic t_chop();
        int n;
        set_cfg(0, 3, 6, 20);
        set_cfg(1, 0, 1, 3);
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        en = 2'b11;
        @(negedge clk);
        chk_eq("R2 drive first cycle", int'(drive_on[0]), 1);
        run_len(0, 1'b0, n);
        chk_eq("R5 on length M dominates", n, 6);
        chk_eq("R3 recirc after trip", int'(recirc_on[0]), 1);
        chk_eq("R3 trip pulse high", int'(trip_pulse[0]), 1);
        @(negedge clk);
        chk_eq("R3 trip pulse single cycle", int'(trip_pulse[0]), 0);
        run_len(0, 1'b1, n);
        chk_eq("R6 off length remaining", n, 19);
        chk_eq("R6 drive resumes", int'(drive_on[0]), 1);
        run_len(0, 1'b0, n);
        chk_eq("R5 second on length", n, 6);
        chk_eq("R9 lane1 drive unaffected", int'(drive_on[1]), 1);
        chk_eq("R9 lane1 recirc unaffected", int'(recirc_on[1]), 0);
        chk_eq("R9 lane1 no trips", trip1_cnt, 0);
        quiesce();
    endtask

    task automatic t_long_blank();
        int n;
        set_cfg(0, 10, 2, 5);
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        en[0] = 1'b1;
        @(negedge clk);
        run_len(0, 1'b0, n);
        chk_eq("R4 on length blank dominates", n, 11);
        run_len(0, 1'b1, n);
        chk_eq("R6 off length five", n, 5);
        quiesce();
    endtask

    task automatic t_blank_pulse();
        int cnt = 0;
        set_cfg(0, 10, 1, 8);
        en[0]  = 1'b1;
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        raw[0] = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (recirc_on[0]) cnt++;
        end
        chk_eq("R4 pulse in blanking ignored", cnt, 0);
        chk_eq("R4 still driving", int'(drive_on[0]), 1);
        raw[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R4 flag after blanking trips", int'(recirc_on[0]), 1);
        quiesce();
    endtask

    task automatic t_off_zero();
        int n;
        set_cfg(0, 0, 0, 0);
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        en[0] = 1'b1;
        @(negedge clk);
        run_len(0, 1'b0, n);
        chk_eq("R5 zero counts on length", n, 1);
        run_len(0, 1'b1, n);
        chk_eq("R6 zero off count one cycle", n, 1);
        chk_eq("R6 drive after zero off", int'(drive_on[0]), 1);
        quiesce();
    endtask

    task automatic t_off_ignores_flag();
        int n;
        set_cfg(0, 0, 1, 12);
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        en[0] = 1'b1;
        @(negedge clk);
        run_len(0, 1'b0, n);
        chk_eq("R5 one cycle on", n, 1);
        raw[0] = 1'b0;
        run_len(0, 1'b1, n);
        chk_eq("R6 off not cut by flag low", n, 12);
        repeat (20) @(negedge clk);
        chk_eq("R6 drive holds flag low", int'(drive_on[0]), 1);
        chk_eq("R6 no recirc flag low", int'(recirc_on[0]), 0);
        quiesce();
    endtask

    task automatic t_disable();
        int n;
        set_cfg(0, 5, 1, 50);
        raw[0] = 1'b1;
        repeat (4) @(negedge clk);
        en[0] = 1'b1;
        @(negedge clk);
        run_len(0, 1'b0, n);
        chk_eq("R5 on length before disable", n, 6);
        repeat (5) @(negedge clk);
        en[0] = 1'b0;
        @(negedge clk);
        chk_eq("R8 drive idle after disable", int'(drive_on[0]), 0);
        chk_eq("R8 recirc idle after disable", int'(recirc_on[0]), 0);
        repeat (3) @(negedge clk);
        en[0] = 1'b1;
        @(negedge clk);
        chk_eq("R8 drive on re-enable", int'(drive_on[0]), 1);
        run_len(0, 1'b0, n);
        chk_eq("R8 blanking reapplied", n, 6);
        run_len(0, 1'b1, n);
        chk_eq("R8 full off after re-enable", n, 50);
        quiesce();
    endtask

    initial begin : main
        t_reset();
        t_sync_latency();
        t_chop();
        t_long_blank();
        t_blank_pulse();
        t_off_zero();
        t_off_ignores_flag();
        t_disable();
        chk_eq("R10 drive and recirc overlap", both_cnt, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule